// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and the calendar date as packed BCD bytes. A one-cycle pulse on `tick` advances the count by one second. Each field passes its carry to the next: seconds, then minutes, then hours, then the date, the month and the two-digit year. The day of week advances with every date rollover. The hour field works in either a 24-hour or a 12-hour format, chosen by a mode bit inside the hour byte itself. In the 12-hour format a PM flag sits inside the same byte.

A host loads any field through a write strobe, a byte-wide address and a data byte. The seven fields appear in parallel as registered outputs, so software reads back exactly what the counter holds. Month lengths come from a small table. February gets 29 days whenever the two-digit year is a multiple of four, year 00 included.

Top module: `bcd_rtc_core`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD, with the tens digit in bits 6:4 and the units digit in bits 3:0. On a tick at 59 seconds, seconds return to 00 and minutes advance. Minutes at 59 return to 00 and hours advance.
- R2: With hour bit 7 set (24-hour format), the hour counts 00 to 23 with its tens digit in bits 5:4. A tick at 23:59:59 returns the hour to 00 and advances the date.
- R3: With hour bit 7 clear (12-hour format), bit 5 is the PM flag (1 = PM) and the tens digit sits in bit 4. The hour runs 12, 01, …, 11. Going from 11 to 12 inverts the PM flag. Going from 11 PM to 12 AM advances the date.
- R4: The date is BCD with its tens digit in bits 5:4. Months 04, 06, 09 and 11 roll over to day 01 after day 30. Months 01, 03, 05, 07, 08, 10 and 12 roll over after day 31.
- R5: February rolls over after day 29 when the two-digit year is divisible by 4, with 00 counted as divisible. In every other year it rolls over after day 28.
- R6: The month is BCD with its tens digit in bit 4. A rollover from month 12 gives month 01 and advances the year. The year counts 00 to 99 in BCD and wraps to 00.
- R7: The day of week is a value 0 to 6 in bits 2:0. It advances at every date rollover and goes from 6 to 0.
- R8: After reset the fields read as follows: seconds 00, minutes 00, hour byte 00 (12-hour format, PM flag clear), date 01, month 01, year 00, day of week 0.
- R9: A write with `wr_en` high loads `wr_data` into one field. The addresses are: 0 seconds, 1 minutes, 2 hour byte, 3 date, 4 month, 5 year, 6 day of week. A write to any other address changes no field.
- R10: In a cycle with `wr_en` high, a `tick` in the same cycle is discarded. The addressed field takes the written value and every other field keeps its value.
- R11: Bits that no field uses always read 0. These are seconds and minutes bit 7, hour bit 6, date bits 7:6, month bits 7:5 and day-of-week bits 7:3. Written values are masked to match.
- R12: Without a tick or a write, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second advance pulse |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write address (fields 0 to 6) |
| wr_data | input | 8 | Host write data |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte: format bit, PM flag, BCD hour |
| date_o | output | 8 | Date, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| dow_o | output | 8 | Day of week, 0 to 6 |

## Verification
A host write and a tick can arrive in the same cycle. The bench provokes this by raising both strobes on one edge while the time stands at 23:59:59 on the last day of year 99, where a tick taken by mistake would ripple through every field. The write targets the minutes. The check then expects the minutes to hold the written value and the other six fields to hold their previous values. A plain tick that follows must advance from that state as usual.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int FIELD_W = 8;

  typedef enum logic [2:0] {
    FLD_SEC   = 3'd0,
    FLD_MIN   = 3'd1,
    FLD_HOUR  = 3'd2,
    FLD_DATE  = 3'd3,
    FLD_MONTH = 3'd4,
    FLD_YEAR  = 3'd5,
    FLD_DOW   = 3'd6
  } field_e;

  localparam logic [FIELD_W-1:0] MASK_MS    = 8'h7F;
  localparam logic [FIELD_W-1:0] MASK_HOUR  = 8'hBF;
  localparam logic [FIELD_W-1:0] MASK_DATE  = 8'h3F;
  localparam logic [FIELD_W-1:0] MASK_MONTH = 8'h1F;
  localparam logic [FIELD_W-1:0] MASK_YEAR  = 8'hFF;

  // Add one to a packed two-digit BCD value (no upper wrap).
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // Two-digit BCD year divisible by four: tens parity decides which units qualify.
  function automatic logic leap_yr(input logic [7:0] y);
    logic r;
    if (!y[4]) r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    else       r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return r;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mo, input logic leap);
    logic [7:0] r;
    case (mo)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int               W    = 8,
  parameter logic [W-1:0]     LO   = '0,
  parameter logic [W-1:0]     HI   = 8'h59,
  parameter logic [W-1:0]     MASK = 8'h7F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         wrap
);
  import rtc_pkg::*;

  assign wrap = inc && (q >= HI);

  always_ff @(posedge clk) begin
    if (rst)       q <= LO;
    else if (ld)   q <= ld_val & MASK;
    else if (inc)  q <= (q >= HI) ? LO : bcd_inc(q);
  end

  // R1
  field_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q == HI) |=> (q == LO));

  // R12
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !ld) |=> $stable(q));

endmodule

// File: rtl/rtc_hour_ctr.sv
module rtc_hour_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         day_wrap
);
  import rtc_pkg::*;

  logic       mode24;
  logic       pm;
  logic [7:0] nxt;
  logic [7:0] inc12;

  assign mode24 = q[7];
  assign pm     = q[5];
  assign inc12  = bcd_inc({3'b000, q[4:0]});

  assign day_wrap = inc && (mode24 ? (q[5:0] == 6'h23)
                                   : (pm && q[4:0] == 5'h11));

  always_comb begin
    if (mode24) begin
      nxt = (q[5:0] >= 6'h23) ? 8'h80 : (8'h80 | bcd_inc({2'b00, q[5:0]}));
    end else if (q[4:0] == 5'h11) begin
      nxt = {2'b00, ~pm, 5'h12};
    end else if (q[4:0] >= 5'h12) begin
      nxt = {2'b00, pm, 5'h01};
    end else begin
      nxt = {2'b00, pm, inc12[4:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      q <= '0;
    else if (ld)  q <= ld_val & MASK_HOUR;
    else if (inc) q <= nxt;
  end

  // R3
  pm_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && !q[7] && q[4:0] == 5'h11) |=> (q[5] != $past(q[5]) && q[4:0] == 5'h12));

  // R2
  h24_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && q == 8'hA3) |=> (q == 8'h80));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         ld_date,
  input  logic         ld_month,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] year_i,
  output logic [W-1:0] date_q,
  output logic [W-1:0] month_q,
  output logic         year_wrap
);
  import rtc_pkg::*;

  logic [7:0] last_day;
  logic       date_end;

  assign last_day  = month_last(month_q, leap_yr(year_i));
  assign date_end  = inc && (date_q >= last_day);
  assign year_wrap = date_end && (month_q >= 8'h12);

  always_ff @(posedge clk) begin
    if (rst)          date_q <= 8'h01;
    else if (ld_date) date_q <= ld_val & MASK_DATE;
    else if (inc)     date_q <= date_end ? 8'h01 : bcd_inc(date_q);
  end

  always_ff @(posedge clk) begin
    if (rst)           month_q <= 8'h01;
    else if (ld_month) month_q <= ld_val & MASK_MONTH;
    else if (date_end) month_q <= (month_q >= 8'h12) ? 8'h01 : bcd_inc(month_q);
  end

  // R5
  leap_feb_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_date && !ld_month && month_q == 8'h02 && date_q == 8'h28 && year_i == 8'h00)
      |=> (date_q == 8'h29 && month_q == 8'h02));

  // R4
  short_month_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_date && !ld_month && month_q == 8'h04 && date_q == 8'h30)
      |=> (date_q == 8'h01 && month_q == 8'h05));

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int DOW_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sec_o,
  output logic [DATA_W-1:0] min_o,
  output logic [DATA_W-1:0] hour_o,
  output logic [DATA_W-1:0] date_o,
  output logic [DATA_W-1:0] month_o,
  output logic [DATA_W-1:0] year_o,
  output logic [DATA_W-1:0] dow_o
);
  import rtc_pkg::*;

  localparam int NFIELD = 7;
  localparam int NMS    = 2;
  localparam logic [DOW_W-1:0] DOW_LAST = DOW_W'(6);

  logic [NFIELD-1:0] ld;
  logic              step;
  logic [NMS-1:0]    ms_inc;
  logic [NMS-1:0]    ms_wrap;
  logic [DATA_W-1:0] ms_q [NMS];
  logic              day_wrap;
  logic              yr_inc;
  logic              yr_wrap;
  logic [DOW_W-1:0]  dow_q;

  // A write cycle swallows the tick entirely.
  assign step = tick && !wr_en;

  generate
    for (genvar f = 0; f < NFIELD; f++) begin : g_dec
      assign ld[f] = wr_en && (wr_addr == ADDR_W'(f));
    end

    for (genvar i = 0; i < NMS; i++) begin : g_ms
      if (i == 0) begin : g_first
        assign ms_inc[i] = step;
      end else begin : g_chain
        assign ms_inc[i] = ms_wrap[i-1];
      end
      rtc_bcd_field #(.W(DATA_W), .LO(8'h00), .HI(8'h59), .MASK(MASK_MS)) u_ms (
        .clk(clk), .rst(rst), .inc(ms_inc[i]), .ld(ld[i]),
        .ld_val(wr_data), .q(ms_q[i]), .wrap(ms_wrap[i]));
    end
  endgenerate

  rtc_hour_ctr #(.W(DATA_W)) u_hour (
    .clk(clk), .rst(rst), .inc(ms_wrap[NMS-1]), .ld(ld[FLD_HOUR]),
    .ld_val(wr_data), .q(hour_o), .day_wrap(day_wrap));

  rtc_calendar #(.W(DATA_W)) u_cal (
    .clk(clk), .rst(rst), .inc(day_wrap), .ld_date(ld[FLD_DATE]),
    .ld_month(ld[FLD_MONTH]), .ld_val(wr_data), .year_i(year_o),
    .date_q(date_o), .month_q(month_o), .year_wrap(yr_inc));

  rtc_bcd_field #(.W(DATA_W), .LO(8'h00), .HI(8'h99), .MASK(MASK_YEAR)) u_year (
    .clk(clk), .rst(rst), .inc(yr_inc), .ld(ld[FLD_YEAR]),
    .ld_val(wr_data), .q(year_o), .wrap(yr_wrap));

  always_ff @(posedge clk) begin
    if (rst)               dow_q <= '0;
    else if (ld[FLD_DOW])  dow_q <= wr_data[DOW_W-1:0];
    else if (day_wrap)     dow_q <= (dow_q >= DOW_LAST) ? '0 : dow_q + 1'b1;
  end

  assign sec_o = ms_q[0];
  assign min_o = ms_q[1];
  assign dow_o = {{(DATA_W-DOW_W){1'b0}}, dow_q};

  // R10
  wr_over_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tick && wr_addr == ADDR_W'(FLD_MIN))
      |=> (min_o == ($past(wr_data) & MASK_MS) && $stable(sec_o) && $stable(hour_o)));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= ADDR_W'(NFIELD))
      |=> ($stable(sec_o) && $stable(min_o) && $stable(date_o) && $stable(dow_o)));

  // R7
  dow_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (day_wrap && !ld[FLD_DOW] && dow_o == 8'd6) |=> (dow_o == 8'd0));

  // R11
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (!sec_o[7] && !min_o[7] && !hour_o[6] && date_o[7:6] == 2'b00
              && month_o[7:5] == 3'b000));

  // R6
  year_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (yr_wrap && !ld[FLD_YEAR]) |=> (year_o == 8'h00));

endmodule

// File: tb/bcd_rtc_core_test.sv
`timescale 1ns/1ps
module bcd_rtc_core_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o, dow_o;

  int checks = 0;
  int errors = 0;

  // reference model state
  int s, m, h, d, mo, y, dw;
  bit m24;

  always #2.5 clk = ~clk;

  bcd_rtc_core uut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o),
    .date_o(date_o), .month_o(month_o), .year_o(year_o), .dow_o(dow_o));

  function automatic logic [7:0] bcd(input int n);
    return 8'(((n / 10) << 4) | (n % 10));
  endfunction

  function automatic int mlen(input int mon, input int yr);
    if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hour_enc(input int hr, input bit f24);
    int h12;
    if (f24) return 8'h80 | bcd(hr);
    h12 = (hr % 12 == 0) ? 12 : hr % 12;
    return {2'b00, (hr >= 12) ? 1'b1 : 1'b0, bcd(h12)[4:0]};
  endfunction

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "sec",   sec_o,   bcd(s));
    chk(req, "min",   min_o,   bcd(m));
    chk(req, "hour",  hour_o,  hour_enc(h, m24));
    chk(req, "date",  date_o,  bcd(d));
    chk(req, "month", month_o, bcd(mo));
    chk(req, "year",  year_o,  bcd(y));
    chk(req, "dow",   dow_o,   8'(dw));
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_all(input int ns, input int nm, input int nh, input int nd,
                         input int nmo, input int ny, input int ndw, input bit f24);
    s = ns; m = nm; h = nh; d = nd; mo = nmo; y = ny; dw = ndw; m24 = f24;
    wr(8'd0, bcd(s));
    wr(8'd1, bcd(m));
    wr(8'd2, hour_enc(h, m24));
    wr(8'd3, bcd(d));
    wr(8'd4, bcd(mo));
    wr(8'd5, bcd(y));
    wr(8'd6, 8'(dw));
  endtask

  task automatic model_step;
    s++;
    if (s == 60) begin
      s = 0; m++;
      if (m == 60) begin
        m = 0; h++;
        if (h == 24) begin
          h = 0; dw = (dw + 1) % 7; d++;
          if (d > mlen(mo, y)) begin
            d = 1; mo++;
            if (mo > 12) begin mo = 1; y = (y + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic do_tick(input string req);
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    model_step();
    check_all(req);
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk("R8", "sec",   sec_o,   8'h00);
    chk("R8", "min",   min_o,   8'h00);
    chk("R8", "hour",  hour_o,  8'h00);
    chk("R8", "date",  date_o,  8'h01);
    chk("R8", "month", month_o, 8'h01);
    chk("R8", "year",  year_o,  8'h00);
    chk("R8", "dow",   dow_o,   8'h00);

    // R9 loads, R12 hold without tick
    set_all(17, 42, 9, 15, 7, 33, 3, 1'b1);
    check_all("R9");
    repeat (5) @(negedge clk);
    check_all("R12");

    // R1 R2 R7: 24-hour run across midnight
    set_all(0, 58, 23, 28, 2, 1, 6, 1'b1);
    for (int i = 0; i < 200; i++) do_tick("R1_R2_R7");

    // R3: every hour step in 12-hour format
    for (int hr = 0; hr < 24; hr++) begin
      set_all(59, 59, hr, 10, 5, 20, 2, 1'b0);
      do_tick("R3");
    end

    // R4 R5 R6: every month end of every year, plus the day before
    for (int yr = 0; yr < 100; yr++) begin
      for (int mn = 1; mn <= 12; mn++) begin
        set_all(59, 59, 23, mlen(mn, yr) - 1, mn, yr, (yr + mn) % 7, 1'b1);
        do_tick("R4_R5");
        for (int k = 0; k < 3599; k++) model_step();
        s = 59; m = 59; h = 23;
        wr(8'd0, 8'h59); wr(8'd1, 8'h59); wr(8'd2, 8'hA3);
        do_tick("R4_R5_R6");
      end
    end

    // R11 unused bits read zero
    wr(8'd0, 8'hFF); chk("R11", "sec",   sec_o,   8'h7F);
    wr(8'd1, 8'hFF); chk("R11", "min",   min_o,   8'h7F);
    wr(8'd2, 8'hFF); chk("R11", "hour",  hour_o,  8'hBF);
    wr(8'd3, 8'hFF); chk("R11", "date",  date_o,  8'h3F);
    wr(8'd4, 8'hFF); chk("R11", "month", month_o, 8'h1F);
    wr(8'd5, 8'hFF); chk("R11", "year",  year_o,  8'hFF);
    wr(8'd6, 8'hFF); chk("R11", "dow",   dow_o,   8'h07);

    // R9 unmapped addresses change nothing
    set_all(5, 6, 7, 8, 9, 10, 4, 1'b1);
    wr(8'd7, 8'h11);
    wr(8'h86, 8'h22);
    wr(8'hFF, 8'h33);
    check_all("R9");

    // R10 write and tick in the same cycle
    set_all(59, 59, 23, 31, 12, 99, 6, 1'b1);
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 8'd1; wr_data = 8'h42;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    m = 42;
    check_all("R10");
    do_tick("R10");

    // R6 year wrap from 99 with R7 day-of-week wrap
    set_all(59, 59, 23, 31, 12, 99, 6, 1'b1);
    do_tick("R6_R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule